// File: doc/BRIEF.md
# Descriptor Chain Walker

This block serves one endpoint direction. It walks a linked list of 16-byte transfer descriptors that software keeps in memory. For each descriptor it reads the four words through a word-wide memory port. It then decides what to do from the descriptor's flags and checksum:

- pass the buffer address and length to a data mover and wait for it to finish,
- skip the descriptor, or
- halt on it.

After a transfer or a skip, the block writes the descriptor back with the hardware-ownership bit cleared, which returns it to software. It then follows the next-descriptor pointer.

Software drives the block with three command pulses (start, stop, resume) and a start address. It watches the `active` flag and the current-pointer output. The packet transfer itself lives outside this block. It appears here only as a request/acknowledge handshake that returns the number of bytes moved. A static strap selects the transmit or receive rules.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset, `active` is 0, `cur_ptr` is 0, and neither `mem_req` nor `mv_req` is asserted.
- R2: In the cycle after a start pulse, a stopped block has `active` at 1 and `cur_ptr` equal to `start_addr` with its low four bits cleared. A start pulse while `active` is 1 is ignored.
- R3: A descriptor is fetched as four little-endian word reads at `cur_ptr`, +4, +8 and +12.
  - Word 0: byte 0 holds the flags (bit 0 hardware-owned, bit 2 bypass, bit 7 completion notice), byte 1 the checksum, and byte 2 the extended flags (bit 5 trailing zero-length packet).
  - Word 1: next-descriptor address.
  - Word 2: buffer address.
  - Word 3: buffer length in bits 15:0 and received length in bits 31:16.
- R4: A descriptor whose owned bit is 0 moves no data and writes nothing. The block keeps `active` at 1 and `cur_ptr` on that descriptor until a resume pulse, which fetches the same four words again.
- R5: The expected checksum is 0xFF minus the 8-bit sum of all 16 bytes, with byte 1 taken as 0 and flag bit 0 taken as 1. When `csum_chk_en` is 1 and byte 1 differs, `csum_err_evt` pulses and the block halts as in R4 without writing. When `csum_chk_en` is 0, the checksum is ignored.
- R6: For an accepted descriptor, `mv_req` rises with the buffer address, the buffer length and `mv_zlp`, and holds them until `mv_ack`. `mv_zlp` equals extended flag bit 5 in transmit mode and is 0 in receive mode.
- R7: After the move in receive mode, word 3 is written with `mv_xfer_len` in bits 31:16 and the buffer length kept in bits 15:0. In both modes word 0 is then written with bit 0 cleared and every other bit unchanged.
- R8: After the write-back, `cur_ptr` takes the next-descriptor address with its low four bits cleared and fetching continues. `done_evt` pulses once for that descriptor only if its completion-notice flag is set.
- R9: An owned descriptor with the bypass flag set moves no data. It is still written back per R7 (without the receive length word) and advanced per R8.
- R10: In transmit mode, an owned, checksum-valid, non-bypass descriptor with length 0 pulses `len_err_evt` and halts as in R4 with `cur_ptr` on it. In receive mode, length 0 is moved normally.
- R11: A stop pulse clears `active` in the first cycle in which no memory or mover handshake is outstanding; a handshake already in flight completes first. A stop pulse wins over a resume or start in the same cycle.
- R12: `mem_req` and `mv_req` are never asserted together. A memory request keeps its address, direction and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_dir | input | 1 | 1 = transmit rules, 0 = receive rules; change only while stopped |
| csum_chk_en | input | 1 | Enable descriptor checksum checking |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| cmd_resume | input | 1 | Resume pulse |
| start_addr | input | 32 | Address of the first descriptor |
| active | output | 1 | Engine running or waiting |
| cur_ptr | output | 32 | Address of the descriptor being handled |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| mv_req | output | 1 | Data mover request |
| mv_addr | output | 32 | Buffer address |
| mv_len | output | 16 | Buffer length |
| mv_zlp | output | 1 | Append a zero-length packet |
| mv_ack | input | 1 | Data movement complete |
| mv_xfer_len | input | 16 | Bytes moved, valid with `mv_ack` |
| done_evt | output | 1 | Descriptor completed with notice requested |
| csum_err_evt | output | 1 | Checksum mismatch found |
| len_err_evt | output | 1 | Zero-length transmit descriptor found |

## Verification
The bound checker watches these rules on every cycle:
- handshake hygiene: one request at a time, with stable request fields,
- pointer alignment, and that the pointer changes only on an advance,
- that data is never moved for an unowned or bypassed descriptor, or for a zero-length transmit,
- that completion pulses come only for descriptors asking for them,
- the stop latency bound.

Only the bench scenarios can show that the whole chain is walked correctly. That covers the right buffers in the right order, word 0 written back with only the owned bit cleared, and the receive length landing in word 3. It also covers recovery after a halt: a resume after a software fix, or a resume with checking switched off, continues from the same descriptor.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  localparam int WORD_BITS      = 32;
  localparam int WORD_BYTES     = WORD_BITS / 8;
  localparam int DESC_BYTES     = 16;
  localparam int WORDS_PER_DESC = DESC_BYTES / WORD_BYTES;
  localparam int IDX_W          = $clog2(WORDS_PER_DESC);
  localparam int LEN_W          = 16;

  // word slots inside one descriptor
  localparam int WI_FLAGS = 0;
  localparam int WI_NEXT  = 1;
  localparam int WI_BUF   = 2;
  localparam int WI_LEN   = 3;

  // flag byte bits
  localparam int FB_OWN = 0;
  localparam int FB_BYP = 2;
  localparam int FB_IOC = 7;
  // extended flag byte bit
  localparam int EB_ZLP = 5;

  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [WORDS_PER_DESC-1:0][WORD_BITS-1:0] desc_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_EVAL,
    S_MOVE,
    S_WB_LEN,
    S_WB_FLG,
    S_ADV,
    S_WAIT
  } walk_state_t;

  // checksum expected in byte 1: 0xFF minus byte sum (byte 1 as 0, own bit as 1)
  function automatic logic [7:0] desc_csum(input desc_t d);
    logic [7:0] acc;
    logic [7:0] b;
    acc = 8'h00;
    for (int w = 0; w < WORDS_PER_DESC; w++) begin
      for (int k = 0; k < WORD_BYTES; k++) begin
        b = d[w][8*k +: 8];
        if (w == WI_FLAGS && k == 1) b = 8'h00;
        if (w == WI_FLAGS && k == 0) b[FB_OWN] = 1'b1;
        acc = acc + b;
      end
    end
    return 8'hFF - acc;
  endfunction

  function automatic word_t align_desc(input word_t a);
    return a & ~word_t'(DESC_BYTES - 1);
  endfunction

  function automatic word_t word_addr(input word_t base, input logic [IDX_W-1:0] idx);
    return base + (word_t'(idx) << $clog2(WORD_BYTES));
  endfunction

endpackage

// File: rtl/dcw_desc_store.sv
module dcw_desc_store
  import dcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  word_t             cap_word,
  output desc_t             desc
);

  for (genvar g = 0; g < WORDS_PER_DESC; g++) begin : g_word
    logic  hit;
    word_t q;
    assign hit = cap_en && (cap_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= cap_word;
    end
    assign desc[g] = q;
  end

endmodule

// File: rtl/dcw_csum_check.sv
module dcw_csum_check
  import dcw_pkg::*;
(
  input  desc_t       desc,
  input  logic        chk_en,
  output logic [7:0]  csum_want,
  output logic        csum_bad
);

  assign csum_want = desc_csum(desc);
  assign csum_bad  = chk_en && (desc[WI_FLAGS][15:8] != csum_want);

endmodule

// File: rtl/dcw_walk_seq.sv
module dcw_walk_seq
  import dcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_dir,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_resume,
  input  word_t             start_addr,
  input  desc_t             desc,
  input  logic              csum_bad,
  input  logic              mem_ack,
  input  logic              mv_ack,
  input  logic [LEN_W-1:0]  mv_xfer_len,
  output logic              active,
  output word_t             cur_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output word_t             mem_addr,
  output word_t             mem_wdata,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              mv_req,
  output word_t             mv_addr,
  output logic [LEN_W-1:0]  mv_len,
  output logic              mv_zlp,
  output logic              done_evt,
  output logic              csum_err_evt,
  output logic              len_err_evt,
  output logic              adv_evt,
  output logic              stop_pend,
  output logic              hs_busy,
  output logic              desc_own,
  output logic              desc_byp,
  output logic              desc_ioc
);

  walk_state_t       st;
  walk_state_t       eval_next;
  word_t             cur_q;
  logic [IDX_W-1:0]  idx_q;
  logic              stop_q;
  logic [LEN_W-1:0]  rlen_q;
  logic              stop_now;
  logic [7:0]        flags;
  logic [7:0]        ext_flags;
  logic [LEN_W-1:0]  buf_len;
  logic              len_zero_tx;

  assign flags       = desc[WI_FLAGS][7:0];
  assign ext_flags   = desc[WI_FLAGS][23:16];
  assign buf_len     = desc[WI_LEN][LEN_W-1:0];
  assign desc_own    = flags[FB_OWN];
  assign desc_byp    = flags[FB_BYP];
  assign desc_ioc    = flags[FB_IOC];
  assign len_zero_tx = tx_dir && (buf_len == '0);

  assign active    = (st != S_IDLE);
  assign cur_ptr   = cur_q;
  assign stop_pend = stop_q;

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    unique case (st)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = word_addr(cur_q, idx_q);
      end
      S_WB_LEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_addr(cur_q, IDX_W'(WI_LEN));
        mem_wdata = {rlen_q, buf_len};
      end
      S_WB_FLG: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_addr(cur_q, IDX_W'(WI_FLAGS));
        mem_wdata = {desc[WI_FLAGS][WORD_BITS-1:1], 1'b0};
      end
      default: ;
    endcase
  end

  assign cap_en  = (st == S_FETCH) && mem_ack;
  assign cap_idx = idx_q;

  // mover port
  assign mv_req  = (st == S_MOVE);
  assign mv_addr = desc[WI_BUF];
  assign mv_len  = buf_len;
  assign mv_zlp  = tx_dir && ext_flags[EB_ZLP];

  assign hs_busy  = (mem_req && !mem_ack) || (mv_req && !mv_ack);
  assign stop_now = (cmd_stop || stop_q) && !hs_busy && active;

  // events
  assign csum_err_evt = (st == S_EVAL) && desc_own && csum_bad;
  assign len_err_evt  = (st == S_EVAL) && desc_own && !csum_bad && !desc_byp && len_zero_tx;
  assign adv_evt      = (st == S_ADV);
  assign done_evt     = adv_evt && desc_ioc;

  // decision on a freshly fetched descriptor
  always_comb begin
    if (!desc_own)        eval_next = S_WAIT;
    else if (csum_bad)    eval_next = S_WAIT;
    else if (desc_byp)    eval_next = S_WB_FLG;
    else if (len_zero_tx) eval_next = S_WAIT;
    else                  eval_next = S_MOVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur_q  <= '0;
      idx_q  <= '0;
      stop_q <= 1'b0;
      rlen_q <= '0;
    end else if (stop_now) begin
      st     <= S_IDLE;
      idx_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      if (cmd_stop && active) stop_q <= 1'b1;
      unique case (st)
        S_IDLE: begin
          if (cmd_start && !cmd_stop) begin
            cur_q <= align_desc(start_addr);
            idx_q <= '0;
            st    <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            if (idx_q == IDX_W'(WORDS_PER_DESC - 1)) begin
              idx_q <= '0;
              st    <= S_EVAL;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        S_EVAL: st <= eval_next;
        S_MOVE: begin
          if (mv_ack) begin
            rlen_q <= mv_xfer_len;
            st     <= tx_dir ? S_WB_FLG : S_WB_LEN;
          end
        end
        S_WB_LEN: if (mem_ack) st <= S_WB_FLG;
        S_WB_FLG: if (mem_ack) st <= S_ADV;
        S_ADV: begin
          cur_q <= align_desc(desc[WI_NEXT]);
          idx_q <= '0;
          st    <= S_FETCH;
        end
        S_WAIT: begin
          if (cmd_resume) begin
            idx_q <= '0;
            st    <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import dcw_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_dir,
  input  logic         csum_chk_en,
  input  logic         cmd_start,
  input  logic         cmd_stop,
  input  logic         cmd_resume,
  input  logic [31:0]  start_addr,
  output logic         active,
  output logic [31:0]  cur_ptr,
  output logic         mem_req,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic [31:0]  mem_rdata,
  input  logic         mem_ack,
  output logic         mv_req,
  output logic [31:0]  mv_addr,
  output logic [15:0]  mv_len,
  output logic         mv_zlp,
  input  logic         mv_ack,
  input  logic [15:0]  mv_xfer_len,
  output logic         done_evt,
  output logic         csum_err_evt,
  output logic         len_err_evt
);

  desc_t             desc;
  logic              cap_en;
  logic [IDX_W-1:0]  cap_idx;
  logic              csum_bad;
  logic [7:0]        csum_want;
  logic              adv_evt;
  logic              stop_pend;
  logic              hs_busy;
  logic              desc_own;
  logic              desc_byp;
  logic              desc_ioc;

  dcw_desc_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_word (mem_rdata),
    .desc     (desc)
  );

  dcw_csum_check u_csum (
    .desc      (desc),
    .chk_en    (csum_chk_en),
    .csum_want (csum_want),
    .csum_bad  (csum_bad)
  );

  dcw_walk_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_dir       (tx_dir),
    .cmd_start    (cmd_start),
    .cmd_stop     (cmd_stop),
    .cmd_resume   (cmd_resume),
    .start_addr   (start_addr),
    .desc         (desc),
    .csum_bad     (csum_bad),
    .mem_ack      (mem_ack),
    .mv_ack       (mv_ack),
    .mv_xfer_len  (mv_xfer_len),
    .active       (active),
    .cur_ptr      (cur_ptr),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .cap_en       (cap_en),
    .cap_idx      (cap_idx),
    .mv_req       (mv_req),
    .mv_addr      (mv_addr),
    .mv_len       (mv_len),
    .mv_zlp       (mv_zlp),
    .done_evt     (done_evt),
    .csum_err_evt (csum_err_evt),
    .len_err_evt  (len_err_evt),
    .adv_evt      (adv_evt),
    .stop_pend    (stop_pend),
    .hs_busy      (hs_busy),
    .desc_own     (desc_own),
    .desc_byp     (desc_byp),
    .desc_ioc     (desc_ioc)
  );

endmodule

// File: rtl/dcw_checker.sv
module dcw_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_dir,
  input logic         active,
  input logic [31:0]  cur_ptr,
  input logic         mem_req,
  input logic         mem_we,
  input logic [31:0]  mem_addr,
  input logic [31:0]  mem_wdata,
  input logic         mem_ack,
  input logic         mv_req,
  input logic [31:0]  mv_addr,
  input logic [15:0]  mv_len,
  input logic         mv_ack,
  input logic         done_evt,
  input logic         csum_err_evt,
  input logic         len_err_evt,
  input logic         adv_evt,
  input logic         stop_pend,
  input logic         hs_busy,
  input logic         desc_own,
  input logic         desc_byp,
  input logic         desc_ioc
);

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cur_ptr[3:0] == 4'h0)); // R2

  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(adv_evt)) |-> $stable(cur_ptr)); // R8

  AST_MOVE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |-> (desc_own && !desc_byp)); // R6

  AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && !mv_ack) |=> (mv_req && $stable(mv_addr) && $stable(mv_len))); // R6

  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[3:0] == 4'h0) |-> !mem_wdata[0]); // R7

  AST_DONE_IOC: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> desc_ioc); // R8

  AST_CSUM_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err_evt |=> !mv_req); // R5

  AST_TX_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && tx_dir) |-> (mv_len != 16'h0)); // R10

  AST_LEN_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_evt |=> !mv_req); // R10

  AST_STOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pend && !hs_busy) |=> !active); // R11

  AST_SINGLE_HS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mv_req)); // R12

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

endmodule

bind desc_chain_walker dcw_checker u_chk (.*);

// File: tb/desc_chain_walker_bench.sv
module desc_chain_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_dir = 1'b1;
  logic        csum_chk_en = 1'b1;
  logic        cmd_start = 1'b0;
  logic        cmd_stop = 1'b0;
  logic        cmd_resume = 1'b0;
  logic [31:0] start_addr = '0;
  logic        active;
  logic [31:0] cur_ptr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;
  logic        mv_req;
  logic [31:0] mv_addr;
  logic [15:0] mv_len;
  logic        mv_zlp;
  logic        mv_ack;
  logic [15:0] mv_xfer_len;
  logic        done_evt, csum_err_evt, len_err_evt;

  always #2 clk = ~clk;  // 250 MHz

  desc_chain_walker u_desc_chain_walker (.*);

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  // memory: 16 descriptor slots of four words
  logic [31:0] mem [0:63];
  logic [31:0] orig_w0 [0:15];
  int rd_n = 0;
  logic [31:0] rd_log [0:255];
  int mv_n = 0;
  logic [31:0] mv_log_addr [0:255];
  logic [15:0] mv_log_len  [0:255];
  logic        mv_log_zlp  [0:255];
  int done_n = 0, cerr_n = 0, lerr_n = 0, overlap_n = 0;

  function automatic logic [15:0] rx_ret(input logic [15:0] l);
    return (l * 16'd3) ^ 16'h005A;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr[7:2]];
        rd_log[rd_n & 255] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mv_ack      <= 1'b0;
      mv_xfer_len <= '0;
    end else if (mv_req && !mv_ack) begin
      mv_ack      <= 1'b1;
      mv_xfer_len <= rx_ret(mv_len);
      mv_log_addr[mv_n & 255] <= mv_addr;
      mv_log_len[mv_n & 255]  <= mv_len;
      mv_log_zlp[mv_n & 255]  <= mv_zlp;
      mv_n <= mv_n + 1;
    end else mv_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (done_evt)         done_n    <= done_n + 1;
      if (csum_err_evt)     cerr_n    <= cerr_n + 1;
      if (len_err_evt)      lerr_n    <= lerr_n + 1;
      if (mem_req && mv_req) overlap_n <= overlap_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench-side checksum: bitwise complement of the adjusted byte sum
  function automatic logic [7:0] bench_csum(input logic [31:0] w0, w1, w2, w3);
    logic [127:0] flat;
    logic [7:0]   s;
    logic [7:0]   b;
    flat = {w3, w2, w1, w0};
    s = 8'h00;
    for (int k = 0; k < 16; k++) begin
      b = flat[8*k +: 8];
      if (k == 1) b = 8'h00;
      if (k == 0) b = b | 8'h01;
      s = s + b;
    end
    return ~s;
  endfunction

  task automatic put_desc(input int slot, input bit own, input bit byp, input bit ioc,
                          input bit zlp, input int nxt, input logic [31:0] bufa,
                          input logic [15:0] len, input bit bad);
    logic [31:0] w0, w1, w2, w3;
    logic [7:0]  c;
    w0 = {8'h00, (zlp ? 8'h20 : 8'h00), 8'h00, ioc, 4'b0000, byp, 1'b0, own};
    w1 = 32'(nxt * 16);
    w2 = bufa;
    w3 = {16'h0000, len};
    c  = bench_csum(w0, w1, w2, w3);
    if (bad) c = c ^ 8'h10;
    w0[15:8] = c;
    mem[slot*4 + 0] = w0;
    mem[slot*4 + 1] = w1;
    mem[slot*4 + 2] = w2;
    mem[slot*4 + 3] = w3;
    orig_w0[slot] = w0;
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk); start_addr = a; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
  endtask
  task automatic pulse_resume();
    @(negedge clk); cmd_resume = 1'b1;
    @(negedge clk); cmd_resume = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic halt_engine();
    pulse_stop();
    idle(4);
  endtask

  // sweep: chains of length n in both directions
  task automatic run_chain(input int n, input bit tx);
    int m0, d0, ioc_cnt;
    logic [15:0] l;
    halt_engine();
    ioc_cnt = 0;
    for (int k = 0; k < n; k++) begin
      l = 16'(k * 53 + n * 7 + 3);
      put_desc(k, 1'b1, 1'b0, (k % 2 == 0), (k % 3 == 1), k + 1,
               32'h8000_0000 | 32'(k << 12) | 32'(n << 4), l, 1'b0);
      if (k % 2 == 0) ioc_cnt++;
    end
    put_desc(n, 1'b0, 1'b0, 1'b1, 1'b0, n + 1, 32'h0, 16'd4, 1'b0);
    m0 = mv_n; d0 = done_n;
    tx_dir = tx;
    pulse_start(32'h0);
    idle(24 * n + 40);
    check("R4 active while stalled", 32'(active), 32'd1);
    check("R8 pointer at chain end", cur_ptr, 32'(n * 16));
    check("R6 move count", 32'(mv_n - m0), 32'(n));
    check("R8 done count", 32'(done_n - d0), 32'(ioc_cnt));
    for (int k = 0; k < n; k++) begin
      l = 16'(k * 53 + n * 7 + 3);
      check("R6 buffer address", mv_log_addr[(m0 + k) & 255],
            32'h8000_0000 | 32'(k << 12) | 32'(n << 4));
      check("R6 buffer length", 32'(mv_log_len[(m0 + k) & 255]), 32'(l));
      check("R6 zlp flag", 32'(mv_log_zlp[(m0 + k) & 255]), 32'(tx && (k % 3 == 1)));
      check("R7 word0 written back", mem[k*4], orig_w0[k] & 32'hFFFF_FFFE);
      check("R7 word3", mem[k*4 + 3], tx ? {16'h0, l} : {rx_ret(l), l});
    end
    check("R4 terminator untouched", mem[n*4], orig_w0[n]);
  endtask

  initial begin
    int m0, r0, c0, l0, d0, lat;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    idle(3);
    check("R1 active after reset", 32'(active), 32'd0);
    check("R1 cur_ptr after reset", cur_ptr, 32'd0);
    check("R1 no mem request", 32'(mem_req), 32'd0);
    check("R1 no mover request", 32'(mv_req), 32'd0);
    rst_n = 1'b1;
    idle(2);
    check("R1 idle after release", 32'(active), 32'd0);

    for (int n = 1; n <= 5; n++) begin
      run_chain(n, 1'b1);
      run_chain(n, 1'b0);
    end

    // R9 bypass in the middle of a transmit chain
    halt_engine();
    tx_dir = 1'b1;
    put_desc(0, 1, 0, 1, 0, 1, 32'hA000_0000, 16'd10, 0);
    put_desc(1, 1, 1, 1, 0, 2, 32'hA000_1000, 16'd11, 0);
    put_desc(2, 1, 0, 1, 0, 3, 32'hA000_2000, 16'd12, 0);
    put_desc(3, 0, 0, 0, 0, 4, 32'h0, 16'd1, 0);
    m0 = mv_n; d0 = done_n;
    pulse_start(32'h0);
    idle(120);
    check("R9 bypass skips move", 32'(mv_n - m0), 32'd2);
    check("R9 second move is third buffer", mv_log_addr[(m0 + 1) & 255], 32'hA000_2000);
    check("R9 bypass written back", mem[4], orig_w0[1] & 32'hFFFF_FFFE);
    check("R9 bypass advances", cur_ptr, 32'd48);
    check("R9 done includes bypass", 32'(done_n - d0), 32'd3);

    // R4 resume on an unowned descriptor fetches it again, then continues once owned
    r0 = rd_n; m0 = mv_n;
    pulse_resume();
    idle(30);
    check("R4 refetch word count", 32'(rd_n - r0), 32'd4);
    check("R4 pointer kept", cur_ptr, 32'd48);
    check("R4 no move on unowned", 32'(mv_n - m0), 32'd0);
    put_desc(3, 1, 0, 0, 0, 4, 32'hB000_0000, 16'd20, 0);
    put_desc(4, 0, 0, 0, 0, 5, 32'h0, 16'd1, 0);
    pulse_resume();
    idle(60);
    check("R4 resumed move", 32'(mv_n - m0), 32'd1);
    check("R4 resumed pointer", cur_ptr, 32'd64);

    // R2 start ignored while active
    pulse_start(32'd160);
    idle(5);
    check("R2 start ignored while active", cur_ptr, 32'd64);

    // R11 stop wins over a simultaneous resume
    m0 = mv_n;
    @(negedge clk); cmd_stop = 1'b1; cmd_resume = 1'b1;
    @(negedge clk); cmd_stop = 1'b0; cmd_resume = 1'b0;
    idle(1);
    check("R11 stop beats resume", 32'(active), 32'd0);
    idle(30);
    check("R11 nothing moved after stop", 32'(mv_n - m0), 32'd0);

    // R2/R3 unaligned start address and word order of the fetch
    put_desc(3, 0, 0, 0, 0, 4, 32'h0, 16'd1, 0);
    r0 = rd_n;
    pulse_start(32'd55);
    idle(30);
    check("R2 start aligned", cur_ptr, 32'd48);
    check("R2 active after start", 32'(active), 32'd1);
    check("R3 fetch read count", 32'(rd_n - r0), 32'd4);
    for (int i = 0; i < 4; i++)
      check("R3 fetch address order", rd_log[(r0 + i) & 255], 32'(48 + 4 * i));

    // R5 checksum mismatch, then accepted with checking off
    halt_engine();
    tx_dir = 1'b1;
    put_desc(0, 1, 0, 0, 0, 1, 32'hC000_0000, 16'd7, 1);
    put_desc(1, 0, 0, 0, 0, 2, 32'h0, 16'd1, 0);
    m0 = mv_n; c0 = cerr_n;
    pulse_start(32'h0);
    idle(60);
    check("R5 checksum error count", 32'(cerr_n - c0), 32'd1);
    check("R5 no move on bad checksum", 32'(mv_n - m0), 32'd0);
    check("R5 pointer held", cur_ptr, 32'd0);
    check("R5 descriptor not written", mem[0], orig_w0[0]);
    check("R5 still active", 32'(active), 32'd1);
    csum_chk_en = 1'b0;
    pulse_resume();
    idle(60);
    check("R5 ignored when disabled", 32'(mv_n - m0), 32'd1);
    check("R5 advanced when disabled", cur_ptr, 32'd16);
    check("R5 no new error when disabled", 32'(cerr_n - c0), 32'd1);
    csum_chk_en = 1'b1;

    // R10 zero length in transmit halts; fix and resume
    halt_engine();
    put_desc(0, 1, 0, 0, 0, 1, 32'hD000_0000, 16'd0, 0);
    put_desc(1, 0, 0, 0, 0, 2, 32'h0, 16'd1, 0);
    m0 = mv_n; l0 = lerr_n;
    pulse_start(32'h0);
    idle(60);
    check("R10 length error count", 32'(lerr_n - l0), 32'd1);
    check("R10 pointer held", cur_ptr, 32'd0);
    check("R10 no move", 32'(mv_n - m0), 32'd0);
    check("R10 descriptor still owned", mem[0], orig_w0[0]);
    put_desc(0, 1, 0, 0, 0, 1, 32'hD000_0000, 16'd9, 0);
    pulse_resume();
    idle(60);
    check("R10 fixed descriptor moved", 32'(mv_log_len[m0 & 255]), 32'd9);
    check("R10 advanced after fix", cur_ptr, 32'd16);

    // R10 zero length in receive is moved
    halt_engine();
    tx_dir = 1'b0;
    put_desc(0, 1, 0, 0, 0, 1, 32'hE000_0000, 16'd0, 0);
    put_desc(1, 0, 0, 0, 0, 2, 32'h0, 16'd1, 0);
    m0 = mv_n; l0 = lerr_n;
    pulse_start(32'h0);
    idle(60);
    check("R10 receive zero length moved", 32'(mv_n - m0), 32'd1);
    check("R10 receive no length error", 32'(lerr_n - l0), 32'd0);
    check("R10 receive advanced", cur_ptr, 32'd16);
    check("R7 receive zero length word3", mem[3], {rx_ret(16'd0), 16'd0});

    // R11 stop latency during a running chain
    halt_engine();
    tx_dir = 1'b1;
    for (int k = 0; k < 5; k++)
      put_desc(k, 1, 0, 0, 0, k + 1, 32'hF000_0000 + 32'(k), 16'(k + 30), 0);
    put_desc(5, 0, 0, 0, 0, 6, 32'h0, 16'd1, 0);
    pulse_start(32'h0);
    idle(13);
    pulse_stop();
    lat = 0;
    while (active && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check("R11 stop latency bounded", 32'(lat <= 2), 32'd1);
    check("R11 no request after stop", 32'(mem_req || mv_req), 32'd0);

    check("R12 no overlapping requests", 32'(overlap_n), 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

endmodule